// File: doc/BRIEF.md
# Segment PIN Access Controller

This block guards a small byte-addressed memory that is split into equal segments. Each segment owns an 8-bit management word, and that word decides four things: whether the segment can be read, whether it can be written, whether either kind of access first needs a PIN, and whether the segment is frozen for good. Each segment also holds four 16-byte key slots: a read PIN, a write PIN, an edit PIN and a name. The name is accepted as an additional PIN for both reads and writes. A small set of master PINs is fixed when the block is built, cannot be changed, and is accepted on every segment for every right.

The host presents a PIN that has already been decrypted on the PIN port, together with a segment number. The block compares that PIN with all of the segment's loaded key slots and with the master PINs. The rights that match are held as a session for that segment. The session ends when the host clears it, or when any port addresses a different segment.

Requests that lack permission are not reported as errors. A write without permission is dropped. A read without permission returns zero. A management write or a key load goes through only when the session holds the edit right and the segment is not locked.

Top module: `segpin_guard`

## Requirements
- R1: After reset every management word reads 0x00, no key slot is loaded, no session is open and every data byte is 0x00.
- R2: The management word bit positions are: bit 7 means writes need a PIN, bit 6 means reads need a PIN, bit 5 enables reads, bit 4 enables writes, and bit 0 locks the segment. The value 0xB0 therefore allows reads with no PIN and allows writes only with a PIN.
- R3: A pulse on pin_valid opens a session for pin_seg from the next cycle. The session holds the read right if the PIN equals the loaded read PIN, the loaded name or a master PIN. It holds the write right if the PIN equals the loaded write PIN, the loaded name or a master PIN. It holds the edit right only if the PIN equals the loaded edit PIN or a master PIN. A slot that has never been loaded matches nothing. The key_sel codes are 0 for the read PIN, 1 for the write PIN, 2 for the edit PIN and 3 for the name.
- R4: A write is performed only when writes are enabled, the segment is unlocked, and either no PIN is needed or the session for that segment holds the write right. Any other write leaves the memory unchanged.
- R5: A read returns the stored byte only when reads are enabled and either no PIN is needed or the session for that segment holds the read right. Any other read returns 0x00.
- R6: A management write or a key load takes effect only when an open session for that segment holds the edit right. Any other such write is ignored.
- R7: Once a segment's lock bit is set, it stays set. After that, data writes, management writes and key loads to that segment are refused, even with a master PIN, while reads still follow the management word.
- R8: A session ends in the cycle after pin_clear is pulsed, and in the cycle after any request, management write or key load addresses a different segment. The access to the other segment is judged without the session. pin_clear takes priority over a PIN presented in the same cycle.
- R9: The comparison covers all 16 bytes. A PIN that differs from a key in only its first byte, or in only its last byte, grants nothing from that key.
- R10: Every read request gives rsp_valid with its data exactly one cycle later. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Data request strobe |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 6 | Byte address; the top 2 bits select the segment |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 8 | Read data, 0x00 when the read is denied |
| pin_valid | input | 1 | Present a decrypted PIN |
| pin_seg | input | 2 | Segment that the PIN is presented for |
| pin_data | input | 128 | Decrypted PIN |
| pin_clear | input | 1 | Close the session |
| mg_we | input | 1 | Management word write strobe |
| mg_seg | input | 2 | Segment of the management write |
| mg_wdata | input | 8 | New management word |
| mg_rsel | input | 2 | Segment whose management word is shown |
| mg_rdata | output | 8 | Management word of segment mg_rsel |
| key_we | input | 1 | Key slot load strobe |
| key_seg | input | 2 | Segment of the key load |
| key_sel | input | 2 | Key slot: 0 read PIN, 1 write PIN, 2 edit PIN, 3 name |
| key_data | input | 128 | New key value |

## Verification
The directed cases cover these patterns:
- The 0xB0 configuration, used to tell free reads apart from PIN-gated writes.
- Wrong PINs that differ only in the first byte or only in the last byte, which separate a full-width comparison from a partial one.
- A name used as a PIN, which must grant read and write rights but not the edit right.
- A locked segment touched with a master PIN, which shows that the lock outranks every right.
- Accesses to a second segment and pin_clear pulses, which show that a session really ends.

A seeded random phase then mixes PIN presentations of every kind with reads, writes, management writes and key loads on random segments. An independent model predicts every response and management readback.

// File: rtl/segpin_pkg.sv
package segpin_pkg;

  localparam int MB_WPIN = 7;
  localparam int MB_RPIN = 6;
  localparam int MB_RDEN = 5;
  localparam int MB_WREN = 4;
  localparam int MB_LOCK = 0;

  localparam int NUM_SLOTS = 4;

  typedef enum logic [1:0] {
    KEY_RD   = 2'd0,
    KEY_WR   = 2'd1,
    KEY_ED   = 2'd2,
    KEY_NAME = 2'd3
  } key_sel_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ed;
  } rights_t;

  function automatic logic read_ok(logic [7:0] m, logic hit, rights_t r);
    return m[MB_RDEN] && (!m[MB_RPIN] || (hit && r.rd));
  endfunction

  function automatic logic write_ok(logic [7:0] m, logic hit, rights_t r);
    return m[MB_WREN] && !m[MB_LOCK] && (!m[MB_WPIN] || (hit && r.wr));
  endfunction

  function automatic logic edit_ok(logic [7:0] m, logic hit, rights_t r);
    return !m[MB_LOCK] && hit && r.ed;
  endfunction

  function automatic rights_t make_rights(logic [NUM_SLOTS-1:0] slot_hit,
                                          logic master_hit);
    rights_t g;
    g.rd = slot_hit[KEY_RD] | slot_hit[KEY_NAME] | master_hit;
    g.wr = slot_hit[KEY_WR] | slot_hit[KEY_NAME] | master_hit;
    g.ed = slot_hit[KEY_ED] | master_hit;
    return g;
  endfunction

endpackage

// File: rtl/segpin_cfg_file.sv
module segpin_cfg_file
  import segpin_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 2,
  parameter int PIN_W   = 128
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             mg_wr,
  input  logic [SEG_W-1:0]                 mg_seg,
  input  logic [7:0]                       mg_wdata,
  input  logic                             key_wr,
  input  logic [SEG_W-1:0]                 key_seg,
  input  logic [1:0]                       key_sel,
  input  logic [PIN_W-1:0]                 key_data,
  output logic [NUM_SEG*8-1:0]             mgmt_flat,
  output logic [NUM_SEG*NUM_SLOTS*PIN_W-1:0] key_flat,
  output logic [NUM_SEG*NUM_SLOTS-1:0]     kset_flat
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [7:0]                      mw;
    logic [NUM_SLOTS-1:0][PIN_W-1:0] kv;
    logic [NUM_SLOTS-1:0]            ks;

    always_ff @(posedge clk) begin
      if (rst) begin
        mw <= '0;
        kv <= '0;
        ks <= '0;
      end else begin
        if (mg_wr && mg_seg == SEG_W'(s)) mw <= mg_wdata;
        if (key_wr && key_seg == SEG_W'(s)) begin
          kv[key_sel] <= key_data;
          ks[key_sel] <= 1'b1;
        end
      end
    end

    assign mgmt_flat[s*8 +: 8]                           = mw;
    assign key_flat[s*NUM_SLOTS*PIN_W +: NUM_SLOTS*PIN_W] = kv;
    assign kset_flat[s*NUM_SLOTS +: NUM_SLOTS]           = ks;
  end

endmodule

// File: rtl/segpin_pin_match.sv
module segpin_pin_match
  import segpin_pkg::*;
#(
  parameter int NUM_SEG    = 4,
  parameter int SEG_W      = 2,
  parameter int PIN_W      = 128,
  parameter int NUM_MASTER = 2,
  parameter logic [NUM_MASTER*PIN_W-1:0] MASTER_PINS = '0
) (
  input  logic [SEG_W-1:0]                   pin_seg,
  input  logic [PIN_W-1:0]                   pin_data,
  input  logic [NUM_SEG*NUM_SLOTS*PIN_W-1:0] key_flat,
  input  logic [NUM_SEG*NUM_SLOTS-1:0]       kset_flat,
  output rights_t                            grant
);

  logic [NUM_SLOTS-1:0][PIN_W-1:0] sk;
  logic [NUM_SLOTS-1:0]            sset;
  logic [NUM_SLOTS-1:0]            slot_hit;
  logic [NUM_MASTER-1:0]           m_hit;

  assign sk   = key_flat[int'(pin_seg)*NUM_SLOTS*PIN_W +: NUM_SLOTS*PIN_W];
  assign sset = kset_flat[int'(pin_seg)*NUM_SLOTS +: NUM_SLOTS];

  // Every byte goes through the XOR and the OR-reduction, so there is no early exit.
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slot_hit[k] = sset[k] && ~|(sk[k] ^ pin_data);
  end

  for (genvar m = 0; m < NUM_MASTER; m++) begin : g_master
    assign m_hit[m] = ~|(MASTER_PINS[m*PIN_W +: PIN_W] ^ pin_data);
  end

  assign grant = make_rights(slot_hit, |m_hit);

endmodule

// File: rtl/segpin_session.sv
module segpin_session
  import segpin_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_valid,
  input  logic [SEG_W-1:0] pin_seg,
  input  rights_t          grant,
  input  logic             pin_clear,
  input  logic             foreign_touch,
  output logic             sess_valid,
  output logic [SEG_W-1:0] sess_seg,
  output rights_t          sess_rights
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sess_valid  <= 1'b0;
      sess_seg    <= '0;
      sess_rights <= '0;
    end else if (pin_clear) begin
      sess_valid  <= 1'b0;
      sess_rights <= '0;
    end else if (pin_valid) begin
      sess_valid  <= 1'b1;
      sess_seg    <= pin_seg;
      sess_rights <= grant;
    end else if (foreign_touch) begin
      sess_valid  <= 1'b0;
      sess_rights <= '0;
    end
  end

endmodule

// File: rtl/segpin_data_mem.sv
module segpin_data_mem #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic              rd_req,
  input  logic              rd_allow,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_fire) mem[addr] <= wdata;
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_allow ? mem[addr] : 8'h00;
    end
  end

endmodule

// File: rtl/segpin_guard.sv
module segpin_guard
  import segpin_pkg::*;
#(
  parameter int NUM_SEG    = 4,
  parameter int SEG_BYTES  = 16,
  parameter int PIN_BYTES  = 16,
  parameter int NUM_MASTER = 2,
  parameter logic [NUM_MASTER*PIN_BYTES*8-1:0] MASTER_PINS =
    {128'hC3A5_0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2,
     128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int OFF_W  = $clog2(SEG_BYTES),
  localparam int ADDR_W = SEG_W + OFF_W,
  localparam int PIN_W  = PIN_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  input  logic              pin_valid,
  input  logic [SEG_W-1:0]  pin_seg,
  input  logic [PIN_W-1:0]  pin_data,
  input  logic              pin_clear,
  input  logic              mg_we,
  input  logic [SEG_W-1:0]  mg_seg,
  input  logic [7:0]        mg_wdata,
  input  logic [SEG_W-1:0]  mg_rsel,
  output logic [7:0]        mg_rdata,
  input  logic              key_we,
  input  logic [SEG_W-1:0]  key_seg,
  input  logic [1:0]        key_sel,
  input  logic [PIN_W-1:0]  key_data
);

  localparam int DEPTH = NUM_SEG * SEG_BYTES;

  logic [NUM_SEG*8-1:0]               mgmt_flat;
  logic [NUM_SEG*NUM_SLOTS*PIN_W-1:0] key_flat;
  logic [NUM_SEG*NUM_SLOTS-1:0]       kset_flat;
  rights_t                            grant;
  logic                               sess_valid;
  logic [SEG_W-1:0]                   sess_seg;
  rights_t                            sess_rights;

  // Internal events, named so that the checker can watch them.
  logic [SEG_W-1:0] req_seg;
  logic [7:0]       req_mgmt, mg_mgmt, key_mgmt;
  logic             hit_req, hit_mg, hit_key;
  logic             rd_grant, data_wr_fire, cfg_wr_fire, key_wr_fire;
  logic             foreign_touch;
  logic [NUM_SEG-1:0] lock_vec;

  assign req_seg  = req_addr[ADDR_W-1:OFF_W];
  assign req_mgmt = mgmt_flat[int'(req_seg)*8 +: 8];
  assign mg_mgmt  = mgmt_flat[int'(mg_seg)*8 +: 8];
  assign key_mgmt = mgmt_flat[int'(key_seg)*8 +: 8];
  assign mg_rdata = mgmt_flat[int'(mg_rsel)*8 +: 8];

  assign hit_req = sess_valid && (sess_seg == req_seg);
  assign hit_mg  = sess_valid && (sess_seg == mg_seg);
  assign hit_key = sess_valid && (sess_seg == key_seg);

  assign rd_grant     = req_valid && !req_we && read_ok(req_mgmt, hit_req, sess_rights);
  assign data_wr_fire = req_valid && req_we && write_ok(req_mgmt, hit_req, sess_rights);
  assign cfg_wr_fire  = mg_we && edit_ok(mg_mgmt, hit_mg, sess_rights);
  assign key_wr_fire  = key_we && edit_ok(key_mgmt, hit_key, sess_rights);

  assign foreign_touch = sess_valid &&
                         ((req_valid && req_seg != sess_seg) ||
                          (mg_we     && mg_seg  != sess_seg) ||
                          (key_we    && key_seg != sess_seg));

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_lock
    assign lock_vec[s] = mgmt_flat[s*8 + MB_LOCK];
  end

  segpin_cfg_file #(
    .NUM_SEG (NUM_SEG),
    .SEG_W   (SEG_W),
    .PIN_W   (PIN_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .mg_wr     (cfg_wr_fire),
    .mg_seg    (mg_seg),
    .mg_wdata  (mg_wdata),
    .key_wr    (key_wr_fire),
    .key_seg   (key_seg),
    .key_sel   (key_sel),
    .key_data  (key_data),
    .mgmt_flat (mgmt_flat),
    .key_flat  (key_flat),
    .kset_flat (kset_flat)
  );

  segpin_pin_match #(
    .NUM_SEG     (NUM_SEG),
    .SEG_W       (SEG_W),
    .PIN_W       (PIN_W),
    .NUM_MASTER  (NUM_MASTER),
    .MASTER_PINS (MASTER_PINS)
  ) u_match (
    .pin_seg   (pin_seg),
    .pin_data  (pin_data),
    .key_flat  (key_flat),
    .kset_flat (kset_flat),
    .grant     (grant)
  );

  segpin_session #(
    .SEG_W (SEG_W)
  ) u_sess (
    .clk           (clk),
    .rst           (rst),
    .pin_valid     (pin_valid),
    .pin_seg       (pin_seg),
    .grant         (grant),
    .pin_clear     (pin_clear),
    .foreign_touch (foreign_touch),
    .sess_valid    (sess_valid),
    .sess_seg      (sess_seg),
    .sess_rights   (sess_rights)
  );

  segpin_data_mem #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_mem (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (data_wr_fire),
    .rd_req    (req_valid && !req_we),
    .rd_allow  (rd_grant),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/segpin_guard_chk.sv
module segpin_guard_chk #(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_we,
  input logic [SEG_W-1:0]   req_seg,
  input logic               rsp_valid,
  input logic [7:0]         rsp_rdata,
  input logic               pin_valid,
  input logic               pin_clear,
  input logic               sess_valid,
  input logic [SEG_W-1:0]   sess_seg,
  input logic               rd_grant,
  input logic               data_wr_fire,
  input logic               cfg_wr_fire,
  input logic               key_wr_fire,
  input logic [NUM_SEG-1:0] lock_vec
);

  // R10
  rd_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> rsp_valid);

  // R10
  rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_we));

  // R5
  deny_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rd_grant)) |-> (rsp_rdata == 8'h00));

  // R8
  clear_end_chk: assert property (@(posedge clk) disable iff (rst)
    pin_clear |=> !sess_valid);

  // R8
  foreign_end_chk: assert property (@(posedge clk) disable iff (rst)
    (sess_valid && req_valid && req_seg != sess_seg && !pin_valid) |=> !sess_valid);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

  // R7
  locked_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr_fire |-> !lock_vec[req_seg]);

  // R6
  cfg_needs_sess_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_fire || key_wr_fire) |-> sess_valid);

endmodule

bind segpin_guard segpin_guard_chk #(
  .NUM_SEG (NUM_SEG),
  .SEG_W   (SEG_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_we       (req_we),
  .req_seg      (req_seg),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .pin_valid    (pin_valid),
  .pin_clear    (pin_clear),
  .sess_valid   (sess_valid),
  .sess_seg     (sess_seg),
  .rd_grant     (rd_grant),
  .data_wr_fire (data_wr_fire),
  .cfg_wr_fire  (cfg_wr_fire),
  .key_wr_fire  (key_wr_fire),
  .lock_vec     (lock_vec)
);

// File: tb/segpin_guard_tb.sv
module segpin_guard_tb;

  localparam logic [127:0] M0 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] M1 = 128'hC3A5_0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 0, req_we = 0;
  logic [5:0]   req_addr = 0;
  logic [7:0]   req_wdata = 0;
  logic         rsp_valid;
  logic [7:0]   rsp_rdata;
  logic         pin_valid = 0, pin_clear = 0;
  logic [1:0]   pin_seg = 0;
  logic [127:0] pin_data = 0;
  logic         mg_we = 0;
  logic [1:0]   mg_seg = 0, mg_rsel = 0;
  logic [7:0]   mg_wdata = 0;
  logic [7:0]   mg_rdata;
  logic         key_we = 0;
  logic [1:0]   key_seg = 0, key_sel = 0;
  logic [127:0] key_data = 0;

  always #2 clk = ~clk;

  segpin_guard #(
    .MASTER_PINS ({M1, M0})
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_valid(pin_valid), .pin_seg(pin_seg),
    .pin_data(pin_data), .pin_clear(pin_clear), .mg_we(mg_we),
    .mg_seg(mg_seg), .mg_wdata(mg_wdata), .mg_rsel(mg_rsel),
    .mg_rdata(mg_rdata), .key_we(key_we), .key_seg(key_seg),
    .key_sel(key_sel), .key_data(key_data)
  );

  // Reference model state
  logic [7:0]   bmem [64];
  logic [7:0]   bmg  [4];
  logic [127:0] bkey [4][4];
  bit           bks  [4][4];
  bit           bs_v, bs_rd, bs_wr, bs_ed;
  int           bs_s;

  int  n_tests = 0, n_fail = 0;
  bit  done = 0;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(logic [127:0] p);
    return (p == M0) || (p == M1);
  endfunction

  function automatic bit slot_ok(int s, int k, logic [127:0] p);
    return bks[s][k] && (bkey[s][k] == p);
  endfunction

  function automatic bit may_rd(int s);
    bit own = bs_v && bs_s == s;
    return bmg[s][5] && (!bmg[s][6] || (own && bs_rd));
  endfunction

  function automatic bit may_wr(int s);
    bit own = bs_v && bs_s == s;
    return bmg[s][4] && !bmg[s][0] && (!bmg[s][7] || (own && bs_wr));
  endfunction

  function automatic bit may_ed(int s);
    return !bmg[s][0] && bs_v && bs_s == s && bs_ed;
  endfunction

  function automatic void touch(int s);
    if (bs_v && bs_s != s) bs_v = 0;
  endfunction

  task automatic present(int s, logic [127:0] p);
    @(negedge clk);
    pin_valid = 1; pin_seg = 2'(s); pin_data = p;
    bs_v  = 1; bs_s = s;
    bs_rd = slot_ok(s, 0, p) || slot_ok(s, 3, p) || m_hit(p);
    bs_wr = slot_ok(s, 1, p) || slot_ok(s, 3, p) || m_hit(p);
    bs_ed = slot_ok(s, 2, p) || m_hit(p);
    @(negedge clk);
    pin_valid = 0;
  endtask

  task automatic clear_pin();
    @(negedge clk);
    pin_clear = 1; bs_v = 0;
    @(negedge clk);
    pin_clear = 0;
  endtask

  task automatic wr_byte(int a, logic [7:0] d, string req);
    int s = a / 16;
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 6'(a); req_wdata = d;
    if (may_wr(s)) bmem[a] = d;
    touch(s);
    @(negedge clk);
    req_valid = 0; req_we = 0;
    check({req, " R10 no rsp on write"}, rsp_valid, 1'b0);
  endtask

  task automatic rd_byte(int a, string req);
    int s = a / 16;
    logic [7:0] e;
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = 6'(a);
    e = may_rd(s) ? bmem[a] : 8'h00;
    touch(s);
    @(negedge clk);
    req_valid = 0;
    check({req, " R10 rsp_valid"}, rsp_valid, 1'b1);
    check({req, " read data"}, rsp_rdata, e);
  endtask

  task automatic mg_write(int s, logic [7:0] v, string req);
    @(negedge clk);
    mg_we = 1; mg_seg = 2'(s); mg_wdata = v;
    if (may_ed(s)) bmg[s] = v;
    touch(s);
    @(negedge clk);
    mg_we = 0; mg_rsel = 2'(s);
    #1 check({req, " mgmt readback"}, mg_rdata, bmg[s]);
  endtask

  task automatic key_load(int s, int k, logic [127:0] v);
    @(negedge clk);
    key_we = 1; key_seg = 2'(s); key_sel = 2'(k); key_data = v;
    if (may_ed(s)) begin bkey[s][k] = v; bks[s][k] = 1; end
    touch(s);
    @(negedge clk);
    key_we = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] wpin, npin, rpin;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) bmem[i] = 0;
    for (int s = 0; s < 4; s++) begin
      bmg[s] = 0;
      for (int k = 0; k < 4; k++) begin bkey[s][k] = 0; bks[s][k] = 0; end
    end
    bs_v = 0; bs_s = 0; bs_rd = 0; bs_wr = 0; bs_ed = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      mg_rsel = 2'(s);
      #1 check("R1 mgmt reset", mg_rdata, 8'h00);
    end
    check("R1 idle rsp_valid", rsp_valid, 1'b0);
    rd_byte(0, "R1 R5 reset read");
    // R1: an all-zero PIN must not match the unloaded slots
    present(0, 128'h0);
    mg_write(0, 8'h30, "R1 R3 zero pin no edit");

    // R2: the 0xB0 configuration on segment 1
    wpin = 128'hAAAA_5555_1111_2222_3333_4444_6666_7777;
    present(1, M0);
    mg_write(1, 8'hB0, "R2 R6 set 0xB0");
    key_load(1, 1, wpin);
    bmem[16] = 8'h00;
    clear_pin();
    wr_byte(16, 8'hAA, "R4");
    rd_byte(16, "R2 R4 write dropped, free read");
    // R9: mismatch in the first byte only, then in the last byte only
    present(1, wpin ^ {8'h01, 120'h0});
    wr_byte(16, 8'hAA, "R9");
    rd_byte(16, "R9 first byte mismatch");
    present(1, wpin ^ 128'h80);
    wr_byte(16, 8'hAA, "R9");
    rd_byte(16, "R9 last byte mismatch");
    present(1, wpin);
    wr_byte(16, 8'hAA, "R3");
    rd_byte(16, "R3 write pin grants write");

    // R3: the name acts as a PIN for data but not for the edit right
    npin = 128'h1357_9BDF_2468_ACE0_0F0F_F0F0_1234_5678;
    present(1, M1);
    key_load(1, 3, npin);
    present(1, npin);
    wr_byte(17, 8'h5C, "R3");
    rd_byte(17, "R3 name grants write");
    mg_write(1, 8'h00, "R3 R6 name has no edit right");

    // R6: no session, and a write-only session
    clear_pin();
    mg_write(1, 8'h30, "R6 no session");
    present(1, wpin);
    mg_write(1, 8'h30, "R6 write pin no edit");

    // R8: touching another segment ends the session, and so does clear
    present(1, wpin);
    rd_byte(32, "R8 foreign read");
    wr_byte(18, 8'h77, "R8");
    rd_byte(18, "R8 session ended by other segment");
    present(1, wpin);
    clear_pin();
    wr_byte(18, 8'h78, "R8");
    rd_byte(18, "R8 session ended by clear");

    // R7: lock
    present(3, M0);
    mg_write(3, 8'h30, "R7 setup");
    wr_byte(48, 8'h55, "R7");
    mg_write(3, 8'h31, "R7 set lock");
    wr_byte(48, 8'h66, "R7");
    rd_byte(48, "R7 locked data unchanged");
    mg_write(3, 8'h30, "R7 lock refuses mgmt");
    present(3, M0);
    mg_write(3, 8'h30, "R7 lock outranks master");

    // R5: reads that need a PIN
    rpin = 128'hFACE_B00C_DEAD_BEEF_0BAD_F00D_CAFE_D00D;
    present(0, M0);
    mg_write(0, 8'h70, "R5 setup");
    key_load(0, 0, rpin);
    wr_byte(5, 8'h3C, "R5");
    clear_pin();
    rd_byte(5, "R5 read denied returns zero");
    present(0, rpin);
    rd_byte(5, "R5 read pin grants read");

    // Random mix, checked against the model
    for (int i = 0; i < 600; i++) begin
      int s  = $urandom_range(0, 3);
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: begin
          int kind = $urandom_range(0, 5);
          logic [127:0] p;
          if (kind < 4)       p = bkey[s][kind];
          else if (kind == 4) p = ($urandom_range(0, 1) != 0) ? M0 : M1;
          else                p = rnd128();
          present(s, p);
        end
        2:       wr_byte(s*16 + $urandom_range(0, 15), 8'($urandom()), "R4 random");
        3, 4, 5: rd_byte(s*16 + $urandom_range(0, 15), "R5 random");
        6: begin
          logic [7:0] v = 8'($urandom());
          if ($urandom_range(0, 19) != 0) v[0] = 1'b0;
          mg_write(s, v, "R6 random");
        end
        7:       key_load(s, $urandom_range(0, 3), rnd128());
        8:       if ($urandom_range(0, 3) == 0) clear_pin(); else present(s, M0);
        default: present(s, bkey[s][$urandom_range(0, 3)]);
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule